// File: doc/BRIEF.md
# Control-Word Transfer Decoder

This block sits between a wide-word shared memory with 36-bit words and a 16-bit request port on the side of a small processor. Each request names the address of a 36-bit control word. The block fetches that word and classifies it from a six-bit selector field. It then performs the access the word describes:

- a direct read or write of the data carried in the word itself;
- a 16-bit windowed read or write on another word, through an address held in the control word;
- a transfer of one packed byte, with the control word updated and written back afterwards.

Bit 0 is the most significant bit of a 36-bit word. The vector index of bit i is therefore 35−i. The selector is bits 6–11.

The layouts are as follows:

- **Direct words** carry their data in bits 20–35.
- **Windowed words** hold:
  - a read-only flag in bit 0;
  - a window code in bits 1–2;
  - a target address in bits 18–35.
- **Packed words** hold:
  - the bit offset of the next byte in bits 0–5;
  - the size code in bits 6–11;
  - the remaining word count in bits 12–17;
  - the data address in bits 18–35.

Bytes are left-justified in a word. A request is accepted only while `req_ready` is high. Exactly one `resp_valid` pulse completes each request.

Top module: `cword_xfer`

## Requirements
- R1: During and right after reset, `resp_valid`, `acc_violation` and `wc_overflow` are 0, no memory enable is high, and `req_ready` is 1.
- R2: The selector classifies the word as follows:
  - 0 or 7: direct;
  - 2 to 6: packed;
  - 8 to 15: windowed;
  - any other value: rejected with an `acc_violation` pulse, read data 0 and no memory write.
- R3: A direct read returns bits 20–35 of the control word.
- R4: A direct write replaces bits 20–35 of the control word and keeps bits 0–19.
- R5: A windowed read returns 16 bits of the target word. The starting bit depends on the window code: code 0 starts at bit 0, code 1 at bit 16, code 2 at bit 20 and code 3 at bit 2.
- R6: A windowed write changes only the 16 selected bits of the target word.
- R7: A write through a windowed word with bit 0 set is rejected. The block pulses `acc_violation` and leaves memory unchanged.
- R8: Size codes 2, 3, 4, 5 and 6 select byte widths of 16, 12, 8, 7 and 6 bits. A packed read returns the byte starting at the offset, zero-extended to 16 bits.
- R9: After each packed access, the control word is written back with the offset increased by the byte width.
- R10: If the byte does not fit in bits offset..35 and the count is above 1, the access goes to the data address plus 1 at offset 0. The count is decremented in the written-back word.
- R11: A packed request is refused if the count is 0, or if the byte does not fit and the count is 1. When refused, the block touches no memory and sets `wc_overflow`, which stays at 1 until reset.
- R12: A packed write changes only the selected byte's bits in the data word.
- R13: `resp_valid` is a one-cycle pulse, and write responses return data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctl_addr | input | ADDR_W | Address of the control word |
| req_wdata | input | 16 | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Read data, 0 for writes and refused requests |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd_en | output | 1 | Memory read; data appears on mem_rdata one cycle later |
| mem_rdata | input | 36 | Memory read data |
| mem_wr_en | output | 1 | Memory write |
| mem_wdata | output | 36 | Memory write data |
| acc_violation | output | 1 | Pulse alongside resp_valid for a rejected request |
| wc_overflow | output | 1 | Sticky word-count overflow flag |

## Verification
The wrap to the next word and the count exhaustion test are decided in the same cycle from the same control word. A byte that does not fit while the count is 1 must therefore raise the overflow instead of advancing. The bench provokes this with packed words placed near the end of a word at counts 0, 1 and 2. It judges the result by the response, by the flag, and by comparing the whole memory with a bench model, which must show no data access and no written-back word.

// File: rtl/cw_pkg.sv
// Package: shared constants and field helpers for the control-word decoder.
// Assumes MSB-first bit numbering: word bit i lives at vector index 35-i.
package cw_pkg;
    localparam int WORD_W = 36;

    // Byte width for a packed-mode size code (only codes 2..6 are meaningful)
    function automatic logic [4:0] size_of(input logic [5:0] code);
        case (code)
            6'd2:    return 5'd16;
            6'd3:    return 5'd12;
            6'd4:    return 5'd8;
            6'd5:    return 5'd7;
            default: return 5'd6;
        endcase
    endfunction

    // First bit of the 16-bit window for a windowed-mode position code
    function automatic logic [5:0] win_start(input logic [1:0] code);
        case (code)
            2'd0:    return 6'd0;
            2'd1:    return 6'd16;
            2'd2:    return 6'd20;
            default: return 6'd2;
        endcase
    endfunction
endpackage

// File: rtl/cw_class.sv
// Module: cw_class
// Classifies a control word from its six-bit selector. Purely combinational.
// Assumes the selector codes of the three modes are disjoint; all others are reserved.
module cw_class (
    input  logic [5:0] sel,
    output logic       is_imm,
    output logic       is_ind,
    output logic       is_ptr,
    output logic       is_bad
);
    // Map selector value to exactly one class
    always_comb begin
        is_imm = (sel == 6'd0) || (sel == 6'd7);
        is_ptr = (sel >= 6'd2) && (sel <= 6'd6);
        is_ind = (sel[5:3] == 3'b001);
        is_bad = !(is_imm || is_ptr || is_ind);
    end
endmodule

// File: rtl/cw_ptr_step.sv
// Module: cw_ptr_step
// Computes where the next packed byte lives and the updated control word.
// Assumes the word count counts words still available, including the current one.
module cw_ptr_step #(
    parameter int ADDR_W = 18
) (
    input  logic [35:0]       ctl,
    output logic              refuse,
    output logic [5:0]        byte_pos,
    output logic [4:0]        byte_w,
    output logic [ADDR_W-1:0] data_addr,
    output logic [35:0]       ctl_next
);
    import cw_pkg::*;

    logic [5:0]  pos;
    logic [5:0]  cnt;
    logic [17:0] addr;
    logic        fits;
    logic [5:0]  cnt_n;
    logic [17:0] addr_n;

    // Decide fit, wrap or refusal and form the written-back word
    always_comb begin
        pos      = ctl[35:30];
        cnt      = ctl[23:18];
        addr     = ctl[17:0];
        byte_w   = size_of(ctl[29:24]);
        fits     = ({1'b0, pos} + {2'b00, byte_w}) <= 7'd36;
        refuse   = (cnt == 6'd0) || (!fits && cnt == 6'd1);
        byte_pos = fits ? pos : 6'd0;
        addr_n   = fits ? addr : addr + 18'd1;
        cnt_n    = fits ? cnt : cnt - 6'd1;
        data_addr = addr_n[ADDR_W-1:0];
        ctl_next = {byte_pos + {1'b0, byte_w}, ctl[29:24], cnt_n, addr_n};
    end
endmodule

// File: rtl/cw_field.sv
// Module: cw_field
// Extracts a left-justified field of up to 16 bits from a 36-bit word and
// merges new data into the same field. Assumes pos + width <= 36.
module cw_field #(
    parameter int DATA_W = 16
) (
    input  logic [35:0]       word,
    input  logic [5:0]        pos,
    input  logic [4:0]        width,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [35:0]       merged
);
    logic [5:0]  sh;
    logic [35:0] mask;

    // Shift and mask the field for read and for read-modify-write
    always_comb begin
        sh     = 6'd36 - pos - {1'b0, width};
        mask   = (36'h1 << width) - 36'h1;
        rdata  = DATA_W'((word >> sh) & mask);
        merged = (word & ~(mask << sh)) | ((36'(wdata) & mask) << sh);
    end
endmodule

// File: rtl/cword_xfer.sv
// Module: cword_xfer (top)
// Fetches a control word, classifies it and performs the direct, windowed or
// packed access it describes, writing packed words back after each byte.
// Assumes a synchronous memory with one cycle of read latency and one request
// in flight at a time.
module cword_xfer #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_ctl_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [35:0]       mem_rdata,
    output logic              mem_wr_en,
    output logic [35:0]       mem_wdata,
    output logic              acc_violation,
    output logic              wc_overflow
);
    import cw_pkg::*;

    typedef enum logic [1:0] {ST_IDLE, ST_CTL, ST_DAT, ST_CWB} st_e;

    st_e               st;
    logic              op_wr;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] ctl_addr_q;
    logic [ADDR_W-1:0] tgt_addr;
    logic [5:0]        sv_pos;
    logic [4:0]        sv_w;
    logic              sv_ptr;
    logic [35:0]       sv_ctl;

    logic              is_imm, is_ind, is_ptr, is_bad;
    logic              p_refuse;
    logic [5:0]        p_pos;
    logic [4:0]        p_w;
    logic [ADDR_W-1:0] p_addr;
    logic [35:0]       p_ctl;
    logic [5:0]        fu_pos;
    logic [4:0]        fu_w;
    logic [DATA_W-1:0] fu_rd;
    logic [35:0]       fu_merged;
    logic              ro_block;

    cw_class u_class (
        .sel    (mem_rdata[29:24]),
        .is_imm (is_imm),
        .is_ind (is_ind),
        .is_ptr (is_ptr),
        .is_bad (is_bad)
    );

    cw_ptr_step #(.ADDR_W(ADDR_W)) u_step (
        .ctl       (mem_rdata),
        .refuse    (p_refuse),
        .byte_pos  (p_pos),
        .byte_w    (p_w),
        .data_addr (p_addr),
        .ctl_next  (p_ctl)
    );

    cw_field #(.DATA_W(DATA_W)) u_field (
        .word   (mem_rdata),
        .pos    (fu_pos),
        .width  (fu_w),
        .wdata  (wdata_q),
        .rdata  (fu_rd),
        .merged (fu_merged)
    );

    // Direct words use their own data field; later phases use the saved window
    always_comb begin
        fu_pos   = (st == ST_CTL) ? 6'd20 : sv_pos;
        fu_w     = (st == ST_CTL) ? 5'd16 : sv_w;
        ro_block = op_wr && mem_rdata[35];
        req_ready = (st == ST_IDLE);
    end

    // Drive the memory port from the current phase
    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = ctl_addr_q;
        mem_wdata = fu_merged;
        case (st)
            ST_IDLE: begin
                mem_rd_en = req_valid;
                mem_addr  = req_ctl_addr;
            end
            ST_CTL: begin
                if (is_imm && op_wr) begin
                    mem_wr_en = 1'b1;
                end else if (is_ind && !ro_block) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = mem_rdata[ADDR_W-1:0];
                end else if (is_ptr && !p_refuse) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = p_addr;
                end
            end
            ST_DAT: begin
                mem_wr_en = op_wr;
                mem_addr  = tgt_addr;
            end
            default: begin
                mem_wr_en = 1'b1;
                mem_wdata = sv_ctl;
            end
        endcase
    end

    // Sequence the phases and register responses and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= ST_IDLE;
            op_wr         <= 1'b0;
            wdata_q       <= '0;
            ctl_addr_q    <= '0;
            tgt_addr      <= '0;
            sv_pos        <= '0;
            sv_w          <= '0;
            sv_ptr        <= 1'b0;
            sv_ctl        <= '0;
            resp_valid    <= 1'b0;
            resp_rdata    <= '0;
            acc_violation <= 1'b0;
            wc_overflow   <= 1'b0;
        end else begin
            resp_valid    <= 1'b0;
            acc_violation <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    op_wr      <= req_write;
                    wdata_q    <= req_wdata;
                    ctl_addr_q <= req_ctl_addr;
                    st         <= ST_CTL;
                end
                ST_CTL: begin
                    resp_rdata <= '0;
                    if (is_imm) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= op_wr ? '0 : fu_rd;
                        st         <= ST_IDLE;
                    end else if (is_ind && !ro_block) begin
                        tgt_addr <= mem_rdata[ADDR_W-1:0];
                        sv_pos   <= win_start(mem_rdata[34:33]);
                        sv_w     <= 5'd16;
                        sv_ptr   <= 1'b0;
                        st       <= ST_DAT;
                    end else if (is_ptr && !p_refuse) begin
                        tgt_addr <= p_addr;
                        sv_pos   <= p_pos;
                        sv_w     <= p_w;
                        sv_ctl   <= p_ctl;
                        sv_ptr   <= 1'b1;
                        st       <= ST_DAT;
                    end else begin
                        resp_valid    <= 1'b1;
                        acc_violation <= !is_ptr;
                        if (is_ptr) wc_overflow <= 1'b1;
                        st            <= ST_IDLE;
                    end
                end
                ST_DAT: begin
                    resp_rdata <= op_wr ? '0 : fu_rd;
                    resp_valid <= !sv_ptr;
                    st         <= sv_ptr ? ST_CWB : ST_IDLE;
                end
                default: begin
                    resp_valid <= 1'b1;
                    st         <= ST_IDLE;
                end
            endcase
        end
    end

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R13
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wc_overflow |=> wc_overflow); // R11
    AST_OVF_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wc_overflow) |-> $past(!mem_rd_en && !mem_wr_en)); // R11
    AST_VIOL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_violation |-> !$past(mem_wr_en)); // R7
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CTL) |-> ($countones({is_imm, is_ind, is_ptr, is_bad}) == 1)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |-> (!mem_rd_en && !mem_wr_en)); // R1
endmodule

// File: tb/tb_cword_xfer.sv
module tb_cword_xfer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_ctl_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        resp_valid;
    logic [15:0] resp_rdata;
    logic [17:0] mem_addr;
    logic        mem_rd_en;
    logic [35:0] mem_rdata = '0;
    logic        mem_wr_en;
    logic [35:0] mem_wdata;
    logic        acc_violation;
    logic        wc_overflow;

    logic [35:0] mem     [256];
    logic [35:0] ref_mem [256];
    int n_chk = 0;
    int n_fail = 0;
    logic exp_ovf = 1'b0;

    always #10 clk = ~clk;

    cword_xfer dut (.*);

    // Bench memory: one cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
    end

    function automatic logic [35:0] gb(input logic [35:0] w, input int s, input int n);
        logic [35:0] r = '0;
        for (int k = 0; k < n; k++) r = {r[34:0], w[35-(s+k)]};
        return r;
    endfunction

    function automatic logic [35:0] pb(input logic [35:0] w, input int s, input int n, input logic [35:0] v);
        logic [35:0] r = w;
        for (int k = 0; k < n; k++) r[35-(s+k)] = v[n-1-k];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model of one request; updates ref_mem
    task automatic model(input logic [7:0] ca, input bit wr, input logic [15:0] wd,
                         output logic [15:0] er, output bit ev);
        logic [35:0] c = ref_mem[ca];
        int sel = int'(gb(c, 6, 6));
        int starts[4] = '{0, 16, 20, 2};
        er = '0; ev = 1'b0;
        if (sel == 0 || sel == 7) begin
            if (wr) ref_mem[ca] = pb(c, 20, 16, 36'(wd));
            else er = 16'(gb(c, 20, 16));
        end else if (sel >= 8 && sel <= 15) begin
            int st = starts[int'(gb(c, 1, 2))];
            logic [7:0] a = 8'(gb(c, 18, 18));
            if (wr && c[35]) ev = 1'b1;
            else if (wr) ref_mem[a] = pb(ref_mem[a], st, 16, 36'(wd));
            else er = 16'(gb(ref_mem[a], st, 16));
        end else if (sel >= 2 && sel <= 6) begin
            int sz = (sel == 2) ? 16 : (sel == 3) ? 12 : (sel == 4) ? 8 : (sel == 5) ? 7 : 6;
            int pos = int'(gb(c, 0, 6));
            int cnt = int'(gb(c, 12, 6));
            logic [17:0] a = 18'(gb(c, 18, 18));
            if (cnt == 0 || (pos + sz > 36 && cnt == 1)) exp_ovf = 1'b1;
            else begin
                if (pos + sz > 36) begin pos = 0; a = a + 18'd1; cnt = cnt - 1; end
                if (wr) ref_mem[a[7:0]] = pb(ref_mem[a[7:0]], pos, sz, 36'(wd));
                else er = 16'(gb(ref_mem[a[7:0]], pos, sz));
                c = pb(c, 0, 6, 36'(pos + sz));
                c = pb(c, 12, 6, 36'(cnt));
                c = pb(c, 18, 18, 36'(a));
                ref_mem[ca] = c;
            end
        end else ev = 1'b1;
    endtask

    task automatic setw(input logic [7:0] a, input logic [35:0] v);
        mem[a] = v; ref_mem[a] = v;
    endtask

    task automatic run_op(input logic [7:0] ca, input bit wr, input logic [15:0] wd, input string req);
        logic [15:0] er; bit ev; int bad = 0; bit got = 0;
        model(ca, wr, wd, er, ev);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_ctl_addr = {10'd0, ca}; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (resp_valid) begin got = 1; break; end
            @(negedge clk);
        end
        chk(got, {req, " response"}, 36'(got), 36'd1);
        chk(resp_rdata == er, {req, " data"}, 36'(resp_rdata), 36'(er));
        chk(acc_violation == ev, {req, " R7/R2 violation"}, 36'(acc_violation), 36'(ev));
        chk(wc_overflow == exp_ovf, {req, " R11 overflow"}, 36'(wc_overflow), 36'(exp_ovf));
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk(bad == 0, {req, " memory"}, 36'(bad), 36'd0);
        @(negedge clk);
        chk(!resp_valid, "R13 single pulse", 36'(resp_valid), 36'd0);
    endtask

    function automatic logic [35:0] mk_ptr(int pos, int code, int cnt, int a);
        return {6'(pos), 6'(code), 6'(cnt), 18'(a)};
    endfunction

    initial begin
        int seed = $urandom(32'd2024);
        for (int i = 0; i < 256; i++) setw(8'(i), {$urandom(), $urandom()} & 36'hF_FFFF_FFFF);
        repeat (3) @(negedge clk);
        chk(!resp_valid && !acc_violation && !wc_overflow && !mem_rd_en && !mem_wr_en && req_ready,
            "R1 reset", {31'd0, resp_valid, acc_violation, wc_overflow, mem_rd_en, mem_wr_en}, 36'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !wc_overflow, "R1 after reset", 36'(req_ready), 36'd1);

        // Directed: direct mode
        setw(8'd1, 36'h0_00F_1234 | (36'd7 << 24));
        run_op(8'd1, 1'b0, 16'h0, "R3 direct read");
        run_op(8'd1, 1'b1, 16'hBEEF, "R4 direct write");
        run_op(8'd1, 1'b0, 16'h0, "R3 direct readback");
        // Directed: every window code, then a write and a read-only write
        setw(8'd40, 36'h9_ABCD_1357);
        for (int p = 0; p < 4; p++) begin
            setw(8'd2, {1'b0, 2'(p), 3'd0, 6'd8, 6'd0, 18'd40});
            run_op(8'd2, 1'b0, 16'h0, "R5 window read");
        end
        setw(8'd2, {1'b0, 2'd3, 3'd0, 6'd12, 6'd0, 18'd40});
        run_op(8'd2, 1'b1, 16'h5A5A, "R6 window write");
        setw(8'd2, {1'b1, 2'd1, 3'd0, 6'd8, 6'd0, 18'd40});
        run_op(8'd2, 1'b1, 16'hFFFF, "R7 read-only write");
        run_op(8'd2, 1'b0, 16'h0, "R7 read-only read allowed");
        // Reserved selectors
        setw(8'd3, {6'd0, 6'd1, 24'd0});
        run_op(8'd3, 1'b1, 16'h1111, "R2 reserved 1");
        setw(8'd3, {6'd0, 6'd16, 24'd0});
        run_op(8'd3, 1'b0, 16'h0, "R2 reserved 16");
        // Packed: 7-bit bytes across a word boundary, then a write at each size
        setw(8'd4, mk_ptr(0, 5, 2, 50));
        for (int k = 0; k < 6; k++) run_op(8'd4, 1'b0, 16'h0, "R8 R9 R10 packed sequence");
        for (int c = 2; c <= 6; c++) begin
            setw(8'd5, mk_ptr(4, c, 1, 60));
            run_op(8'd5, 1'b1, 16'hFFFF, "R12 packed write");
        end
        // Random mix (overflow not yet raised for most of these)
        for (int n = 0; n < 120; n++) begin
            int kind = int'($urandom() % 4);
            logic [7:0] ca = 8'($urandom() % 16);
            logic [35:0] w = {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
            if (kind == 0) w[29:24] = ($urandom() % 2) ? 6'd7 : 6'd0;
            else if (kind == 1) begin w[29:24] = 6'(8 + $urandom() % 8); w[17:0] = 18'(16 + $urandom() % 240); end
            else if (kind == 2) w = mk_ptr(int'($urandom() % 37), int'(2 + $urandom() % 5), int'(1 + $urandom() % 3), int'(16 + $urandom() % 200));
            else w[29:24] = 6'(16 + $urandom() % 48);
            setw(ca, w);
            run_op(ca, 1'($urandom()), 16'($urandom()), "R2 R3 R5 R8 random");
        end
        // Overflow: no-fit at count 1, then count 0, then it stays set
        setw(8'd6, mk_ptr(30, 4, 1, 70));
        run_op(8'd6, 1'b0, 16'h0, "R11 no fit at count 1");
        setw(8'd6, mk_ptr(0, 2, 0, 70));
        run_op(8'd6, 1'b1, 16'h1234, "R11 count 0");
        setw(8'd6, mk_ptr(30, 4, 2, 70));
        run_op(8'd6, 1'b0, 16'h0, "R10 no fit at count 2");
        chk(wc_overflow, "R11 sticky", 36'(wc_overflow), 36'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R13 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule